// File: doc/BRIEF.md
# Processor Flag Register and RAM Page Selector

This block holds the eight-bit processor status word and uses its paging field to choose the upper RAM page bits for each data-memory operand. The status word carries a two-bit paging mode, a spare bit that stores a value but feeds no logic, a register-space select, a reserved bit, and the carry, zero and global interrupt enable flags. Flag instructions update the whole word by combining it with an immediate through AND, OR or XOR. The ALU's carry and zero strobes load the two arithmetic flags. Interrupt entry clears the whole word.

The page selector takes the current, index and stack page pointers and, for each access, returns a page number and a direct/indexed tag. The paging mode decides whether a direct or an indexed operand goes to page 0 or to one of the pointers. Because interrupt entry forces the paging mode to zero, an interrupt service routine always starts with every operand on page 0.

Top module: `flag_page_unit`

## Requirements
- R1: A synchronous active-high reset clears all eight status bits to 0.
- R2: A flag instruction (fop_kind 00 = AND, 01 = OR, 10 = XOR) with fop_valid high replaces the status word with the old word combined with fop_imm. The new value is visible one clock later.
- R3: A flag instruction with fop_kind 11 has no effect on the status word.
- R4: Status bit 3 is reserved and always reads 0, whatever the immediate holds.
- R5: With alu_valid high and no flag instruction or interrupt entry, bit 2 loads alu_carry and bit 1 loads alu_zero. The other six bits keep their values.
- R6: A flag instruction in the same cycle as an ALU strobe wins, and the ALU strobe is dropped.
- R7: irq_enter clears the whole status word on the next clock and overrides any flag instruction or ALU strobe in the same cycle.
- R8: Paging mode 00 (bits 7:6) sends both direct and indexed accesses to page 0.
- R9: Paging mode 01 sends direct accesses to page 0 and indexed accesses to stk_page.
- R10: Paging mode 10 sends direct accesses to cur_page and indexed accesses to idx_page.
- R11: Paging mode 11 sends direct accesses to cur_page and indexed accesses to stk_page.
- R12: xio_space shows bit 4 and gie shows bit 0. The page outputs follow the access request in the same cycle: acc_page_valid mirrors acc_valid, and acc_page_indexed mirrors acc_indexed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_enter | input | 1 | Interrupt entry; clears the status word |
| fop_valid | input | 1 | Flag instruction strobe |
| fop_kind | input | 2 | 00 AND, 01 OR, 10 XOR, 11 no operation |
| fop_imm | input | 8 | Immediate operand of the flag instruction |
| alu_valid | input | 1 | ALU flag update strobe |
| alu_carry | input | 1 | Carry result from the ALU |
| alu_zero | input | 1 | Zero result from the ALU |
| cur_page | input | PAGE_W | Current page pointer |
| idx_page | input | PAGE_W | Index page pointer |
| stk_page | input | PAGE_W | Stack page pointer |
| acc_valid | input | 1 | Data-memory access request |
| acc_indexed | input | 1 | 1 = indexed operand, 0 = direct operand |
| flags_q | output | 8 | Status word |
| xio_space | output | 1 | Extended register space selected |
| gie | output | 1 | Global interrupt enable |
| acc_page | output | PAGE_W | Selected RAM page for the access |
| acc_page_valid | output | 1 | Page output is valid |
| acc_page_indexed | output | 1 | The selected page is for an indexed operand |

## Verification
A flag instruction, an ALU strobe, interrupt entry or reset changes the status word, and the new value appears one clock after the edge that captures the stimulus. The bench drives each stimulus, waits for one rising edge, and reads flags_q, xio_space and gie 2 ns after that edge. The page outputs are combinational from the registered paging mode and the pointer inputs, so they are due in the same cycle. The bench reads them 1 ns after it changes the access inputs, before the next edge.

// File: rtl/cpuflag_pkg.sv
package cpuflag_pkg;

    typedef enum logic [1:0] {
        FOP_AND  = 2'b00,
        FOP_OR   = 2'b01,
        FOP_XOR  = 2'b10,
        FOP_NONE = 2'b11
    } fop_e;

    typedef enum logic [1:0] {
        PG_ALL_ZERO  = 2'b00,
        PG_STK_INDEX = 2'b01,
        PG_SPLIT     = 2'b10,
        PG_CUR_STK   = 2'b11
    } pg_mode_e;

    typedef struct packed {
        pg_mode_e mode;   // 7:6
        logic     spare;  // 5
        logic     xsel;   // 4
        logic     rsvd;   // 3
        logic     carry;  // 2
        logic     zero;   // 1
        logic     ie;     // 0
    } status_t;

    localparam logic [7:0] STATUS_KEEP_MASK = 8'hF7;

    function automatic status_t apply_fop(input status_t cur, input fop_e kind,
                                          input logic [7:0] imm);
        logic [7:0] res;
        case (kind)
            FOP_AND: res = cur & imm;
            FOP_OR:  res = cur | imm;
            FOP_XOR: res = cur ^ imm;
            default: res = cur;
        endcase
        return status_t'(res & STATUS_KEEP_MASK);
    endfunction

endpackage

// File: rtl/fpu_status_reg.sv
module fpu_status_reg
    import cpuflag_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       irq_enter,
    input  logic       fop_valid,
    input  fop_e       fop_kind,
    input  logic [7:0] fop_imm,
    input  logic       alu_valid,
    input  logic       alu_carry,
    input  logic       alu_zero,
    output status_t    status_q
);
    status_t status_d;
    logic    fop_live;

    assign fop_live = fop_valid && (fop_kind != FOP_NONE);

    always_comb begin
        status_d = status_q;
        if (irq_enter) begin
            status_d = '0;
        end else if (fop_live) begin
            status_d = apply_fop(status_q, fop_kind, fop_imm);
        end else if (alu_valid) begin
            status_d.carry = alu_carry;
            status_d.zero  = alu_zero;
        end
        status_d.rsvd = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= status_d;
    end
endmodule

// File: rtl/fpu_page_select.sv
module fpu_page_select
    import cpuflag_pkg::*;
#(
    parameter int PAGE_W = 4
) (
    input  pg_mode_e          mode,
    input  logic [PAGE_W-1:0] cur_page,
    input  logic [PAGE_W-1:0] idx_page,
    input  logic [PAGE_W-1:0] stk_page,
    input  logic              acc_valid,
    input  logic              acc_indexed,
    output logic [PAGE_W-1:0] page,
    output logic              page_valid,
    output logic              page_indexed
);
    localparam logic [PAGE_W-1:0] PAGE_ZERO = '0;

    logic [PAGE_W-1:0] direct_pg;
    logic [PAGE_W-1:0] indexed_pg;

    always_comb begin
        unique case (mode)
            PG_ALL_ZERO:  begin direct_pg = PAGE_ZERO; indexed_pg = PAGE_ZERO; end
            PG_STK_INDEX: begin direct_pg = PAGE_ZERO; indexed_pg = stk_page;  end
            PG_SPLIT:     begin direct_pg = cur_page;  indexed_pg = idx_page;  end
            default:      begin direct_pg = cur_page;  indexed_pg = stk_page;  end
        endcase
    end

    assign page         = acc_indexed ? indexed_pg : direct_pg;
    assign page_valid   = acc_valid;
    assign page_indexed = acc_indexed;
endmodule

// File: rtl/flag_page_unit.sv
module flag_page_unit
    import cpuflag_pkg::*;
#(
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              irq_enter,
    input  logic              fop_valid,
    input  logic [1:0]        fop_kind,
    input  logic [7:0]        fop_imm,
    input  logic              alu_valid,
    input  logic              alu_carry,
    input  logic              alu_zero,
    input  logic [PAGE_W-1:0] cur_page,
    input  logic [PAGE_W-1:0] idx_page,
    input  logic [PAGE_W-1:0] stk_page,
    input  logic              acc_valid,
    input  logic              acc_indexed,
    output logic [7:0]        flags_q,
    output logic              xio_space,
    output logic              gie,
    output logic [PAGE_W-1:0] acc_page,
    output logic              acc_page_valid,
    output logic              acc_page_indexed
);
    status_t status_q;

    fpu_status_reg u_status (
        .clk       (clk),
        .rst       (rst),
        .irq_enter (irq_enter),
        .fop_valid (fop_valid),
        .fop_kind  (fop_e'(fop_kind)),
        .fop_imm   (fop_imm),
        .alu_valid (alu_valid),
        .alu_carry (alu_carry),
        .alu_zero  (alu_zero),
        .status_q  (status_q)
    );

    fpu_page_select #(.PAGE_W(PAGE_W)) u_page (
        .mode         (status_q.mode),
        .cur_page     (cur_page),
        .idx_page     (idx_page),
        .stk_page     (stk_page),
        .acc_valid    (acc_valid),
        .acc_indexed  (acc_indexed),
        .page         (acc_page),
        .page_valid   (acc_page_valid),
        .page_indexed (acc_page_indexed)
    );

    assign flags_q   = status_q;
    assign xio_space = status_q.xsel;
    assign gie       = status_q.ie;
endmodule

// File: rtl/flag_page_unit_chk.sv
module flag_page_unit_chk #(
    parameter int PAGE_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              irq_enter,
    input logic              fop_valid,
    input logic [1:0]        fop_kind,
    input logic              alu_valid,
    input logic              alu_carry,
    input logic [PAGE_W-1:0] stk_page,
    input logic              acc_valid,
    input logic              acc_indexed,
    input logic [7:0]        flags_q,
    input logic [PAGE_W-1:0] acc_page
);
    a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> flags_q == 8'h00);

    a_r4_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        flags_q[3] == 1'b0);

    a_r7_irq_clears: assert property (@(posedge clk) disable iff (rst)
        irq_enter |=> flags_q == 8'h00);

    a_r3_nop_kind_keeps: assert property (@(posedge clk) disable iff (rst)
        (fop_valid && fop_kind == 2'b11 && !alu_valid && !irq_enter) |=> $stable(flags_q));

    a_r5_alu_only_arith: assert property (@(posedge clk) disable iff (rst)
        (alu_valid && !fop_valid && !irq_enter) |=>
        (flags_q[7:3] == $past(flags_q[7:3]) && flags_q[0] == $past(flags_q[0])
         && flags_q[2] == $past(alu_carry)));

    a_r8_mode0_page_zero: assert property (@(posedge clk) disable iff (rst)
        (flags_q[7:6] == 2'b00 && acc_valid) |-> acc_page == '0);

    a_r9_mode1_indexed_stack: assert property (@(posedge clk) disable iff (rst)
        (flags_q[7:6] == 2'b01 && acc_valid && acc_indexed) |-> acc_page == stk_page);
endmodule

bind flag_page_unit flag_page_unit_chk #(.PAGE_W(PAGE_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .irq_enter   (irq_enter),
    .fop_valid   (fop_valid),
    .fop_kind    (fop_kind),
    .alu_valid   (alu_valid),
    .alu_carry   (alu_carry),
    .stk_page    (stk_page),
    .acc_valid   (acc_valid),
    .acc_indexed (acc_indexed),
    .flags_q     (flags_q),
    .acc_page    (acc_page)
);

// File: tb/tb_flag_page_unit.sv
`timescale 1ns/1ps
module tb_flag_page_unit;
    localparam int PAGE_W = 4;

    logic clk = 1'b0;
    logic rst, irq_enter, fop_valid, alu_valid, alu_carry, alu_zero;
    logic [1:0] fop_kind;
    logic [7:0] fop_imm;
    logic [PAGE_W-1:0] cur_page, idx_page, stk_page;
    logic acc_valid, acc_indexed;
    logic [7:0] flags_q;
    logic xio_space, gie, acc_page_valid, acc_page_indexed;
    logic [PAGE_W-1:0] acc_page;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    flag_page_unit #(.PAGE_W(PAGE_W)) dut (
        .clk(clk), .rst(rst), .irq_enter(irq_enter), .fop_valid(fop_valid),
        .fop_kind(fop_kind), .fop_imm(fop_imm), .alu_valid(alu_valid),
        .alu_carry(alu_carry), .alu_zero(alu_zero), .cur_page(cur_page),
        .idx_page(idx_page), .stk_page(stk_page), .acc_valid(acc_valid),
        .acc_indexed(acc_indexed), .flags_q(flags_q), .xio_space(xio_space),
        .gie(gie), .acc_page(acc_page), .acc_page_valid(acc_page_valid),
        .acc_page_indexed(acc_page_indexed)
    );

    // {fop_valid, fop_kind, imm, alu_valid, carry, zero, irq, expected}
    typedef struct packed {
        logic       fv;
        logic [1:0] kind;
        logic [7:0] imm;
        logic       av;
        logic       ac;
        logic       az;
        logic       irq;
        logic [7:0] exp;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'b01, 8'hDD, 1'b0, 1'b0, 1'b0, 1'b0, 8'hD5}, // R2 OR, R4 bit3 masked
        '{1'b1, 2'b00, 8'hF0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hD0}, // R2 AND
        '{1'b1, 2'b10, 8'h3F, 1'b0, 1'b0, 1'b0, 1'b0, 8'hE7}, // R2 XOR, R4
        '{1'b1, 2'b11, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 8'hE7}, // R3 no-op kind
        '{1'b0, 2'b00, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'hE1}, // R5 alu clears C,Z
        '{1'b0, 2'b00, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 8'hE7}, // R5 alu sets C,Z
        '{1'b1, 2'b00, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b0, 8'hE7}, // R6 fop wins
        '{1'b1, 2'b01, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00}, // R7 irq wins
        '{1'b0, 2'b00, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 8'h04}, // R5
        '{1'b1, 2'b10, 8'h80, 1'b1, 1'b0, 1'b1, 1'b0, 8'h84}  // R6 fop wins
    };

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic idle_inputs();
        irq_enter = 0; fop_valid = 0; fop_kind = 2'b00; fop_imm = 8'h00;
        alu_valid = 0; alu_carry = 0; alu_zero = 0;
    endtask

    task automatic clock_and_settle();
        @(posedge clk);
        #2;
    endtask

    task automatic set_mode(input logic [1:0] m);
        idle_inputs();
        irq_enter = 1;
        clock_and_settle();
        idle_inputs();
        fop_valid = 1; fop_kind = 2'b01; fop_imm = {m, 6'b000000};
        clock_and_settle();
        idle_inputs();
    endtask

    task automatic check_pages(input string req, input logic [PAGE_W-1:0] exp_dir,
                               input logic [PAGE_W-1:0] exp_idx);
        acc_valid = 1; acc_indexed = 0;
        #1;
        check({req, " direct"}, 8'(acc_page), 8'(exp_dir));
        acc_indexed = 1;
        #1;
        check({req, " indexed"}, 8'(acc_page), 8'(exp_idx));
        acc_valid = 0; acc_indexed = 0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        idle_inputs();
        rst = 1;
        cur_page = 4'd5; idx_page = 4'd9; stk_page = 4'd12;
        acc_valid = 0; acc_indexed = 0;
        clock_and_settle();
        clock_and_settle();
        check("R1 reset flags", flags_q, 8'h00);
        rst = 0;
        clock_and_settle();
        check("R1 after release", flags_q, 8'h00);

        for (int i = 0; i < NV; i++) begin
            fop_valid = VECS[i].fv; fop_kind = VECS[i].kind; fop_imm = VECS[i].imm;
            alu_valid = VECS[i].av; alu_carry = VECS[i].ac; alu_zero = VECS[i].az;
            irq_enter = VECS[i].irq;
            clock_and_settle();
            check($sformatf("R2-table vec %0d", i), flags_q, VECS[i].exp);
            check("R4 reserved bit", {7'b0, flags_q[3]}, 8'h00);
        end
        idle_inputs();

        // R12: xio_space and gie mirror bits 4 and 0
        fop_valid = 1; fop_kind = 2'b01; fop_imm = 8'h11;
        clock_and_settle();
        idle_inputs();
        check("R12 xio_space", {7'b0, xio_space}, 8'h01);
        check("R12 gie", {7'b0, gie}, 8'h01);
        acc_valid = 1; acc_indexed = 1;
        #1;
        check("R12 page valid", {7'b0, acc_page_valid}, 8'h01);
        check("R12 page indexed", {7'b0, acc_page_indexed}, 8'h01);
        acc_valid = 0; acc_indexed = 0;
        #1;
        check("R12 page idle", {6'b0, acc_page_valid, acc_page_indexed}, 8'h00);

        // R3: no-op kind leaves all bits, including xsel/ie
        fop_valid = 1; fop_kind = 2'b11; fop_imm = 8'h00;
        clock_and_settle();
        idle_inputs();
        check("R3 no-op keeps word", flags_q, 8'h95);

        set_mode(2'b00);
        check("R7 mode after irq", flags_q, 8'h00);
        check_pages("R8 mode 00", 4'd0, 4'd0);
        set_mode(2'b01);
        check_pages("R9 mode 01", 4'd0, 4'd12);
        set_mode(2'b10);
        check_pages("R10 mode 10", 4'd5, 4'd9);
        cur_page = 4'd3; idx_page = 4'd14;
        check_pages("R10 mode 10 new pointers", 4'd3, 4'd14);
        set_mode(2'b11);
        check_pages("R11 mode 11", 4'd3, 4'd12);
        stk_page = 4'd15;
        check_pages("R11 mode 11 new stack", 4'd3, 4'd15);

        // R7: interrupt entry drops paging back to page 0
        irq_enter = 1;
        clock_and_settle();
        idle_inputs();
        check_pages("R7 irq forces page 0", 4'd0, 4'd0);

        // R1: reset mid-run
        fop_valid = 1; fop_kind = 2'b01; fop_imm = 8'hFF;
        clock_and_settle();
        idle_inputs();
        rst = 1;
        clock_and_settle();
        rst = 0;
        check("R1 reset mid-run", flags_q, 8'h00);

        finish_run();
    end
endmodule